// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block links two 8-bit buses, called A and B, and holds one capture register for each direction. The A-to-B register samples the A bus on its own clock. The B-to-A register samples the B bus on a second clock. Both registers load whatever the enable, direction and select inputs are doing.

An active-low enable and a direction input decide which bus is driven, if any. When the enable is high, both sides are isolated. When the enable is low, the direction input picks the one side that is driven. Each direction has its own select input. It chooses between the live value on the opposite bus and the value held in that direction's register. Only one bus is ever driven, so data cannot move both ways at once.

Each bus is modelled as separate input, output and output-enable signals, so no tristate pad is needed. A parameter turns the block into an inverting variant, in which every driven value is the complement of the selected source.

Top module: `regbus_xcvr`

## Requirements
- R1: On each rising edge of `clk_a2b` with `rst` low, the A-to-B register takes the value of `a_in`, whatever the values of `en_n`, `dir`, `sel_a2b` and `sel_b2a`.
- R2: On each rising edge of `clk_b2a` with `rst` low, the B-to-A register takes the value of `b_in`, whatever the values of `en_n`, `dir`, `sel_a2b` and `sel_b2a`.
- R3: A rising edge of either capture clock while `rst` is high clears only that clock's register to zero. The other register keeps its value.
- R4: While `en_n` is 1, both `a_oe` and `b_oe` are 0, and the registers still capture.
- R5: While `en_n` is 0, `dir`=1 gives `b_oe`=1 and `a_oe`=0, and `dir`=0 gives `a_oe`=1 and `b_oe`=0. The two enables are never high together.
- R6: While `b_oe` is 1, `b_out` equals `a_in` when `sel_a2b`=0, and equals the A-to-B register when `sel_a2b`=1.
- R7: While `a_oe` is 1, `a_out` equals `b_in` when `sel_b2a`=0, and equals the B-to-A register when `sel_b2a`=1.
- R8: A bus whose output enable is 0 has its output data at all zeros, whatever the select inputs and the bus data are.
- R9: With `INVERT`=1, the driven output is the bitwise complement of the selected source, for both the live and the stored choice, in both directions. Outputs that are not driven stay zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a2b | input | 1 | Capture clock of the A-to-B register |
| clk_b2a | input | 1 | Capture clock of the B-to-A register |
| rst | input | 1 | Synchronous active-high clear, sampled on each capture clock |
| en_n | input | 1 | Active-low output enable; high isolates both buses |
| dir | input | 1 | 1 drives B from the A side, 0 drives A from the B side |
| sel_a2b | input | 1 | Source for B outputs: 0 live A bus, 1 stored A value |
| sel_b2a | input | 1 | Source for A outputs: 0 live B bus, 1 stored B value |
| a_in | input | W | Data seen on the A bus |
| b_in | input | W | Data seen on the B bus |
| a_out | output | W | Data driven onto the A bus |
| a_oe | output | 1 | A bus driver enable |
| b_out | output | W | Data driven onto the B bus |
| b_oe | output | 1 | B bus driver enable |

## Verification
The only internal state is the two capture registers. A wrong register value is visible at the ports only when the matching direction is driven with its select set to stored. It shows in the same settle time once that control combination is applied. For this reason the bench reads each register through the stored path after every capture, including captures made under isolation or with the opposite direction selected. Every enable, direction and select combination is then swept against several data patterns for both polarities. This exposes a missed load, a load on the wrong clock, or a clear that reaches the wrong register.

// File: rtl/regbus_xcvr.sv
module regbus_xcvr #(
  parameter int W      = 8,
  parameter bit INVERT = 1'b0
) (
  input  logic         clk_a2b,
  input  logic         clk_b2a,
  input  logic         rst,
  input  logic         en_n,
  input  logic         dir,
  input  logic         sel_a2b,
  input  logic         sel_b2a,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] a_out,
  output logic         a_oe,
  output logic [W-1:0] b_out,
  output logic         b_oe
);
  localparam logic [W-1:0] MASK = INVERT ? {W{1'b1}} : '0;

  logic [W-1:0] a2b_q, b2a_q;
  logic [W-1:0] b_src, a_src;

  always_ff @(posedge clk_a2b)
    if (rst) a2b_q <= '0;
    else     a2b_q <= a_in;

  always_ff @(posedge clk_b2a)
    if (rst) b2a_q <= '0;
    else     b2a_q <= b_in;

  assign b_oe  = !en_n &&  dir;
  assign a_oe  = !en_n && !dir;

  assign b_src = sel_a2b ? a2b_q : a_in;
  assign a_src = sel_b2a ? b2a_q : b_in;

  assign b_out = b_oe ? (b_src ^ MASK) : '0;
  assign a_out = a_oe ? (a_src ^ MASK) : '0;
endmodule

// File: rtl/regbus_xcvr_chk.sv
module regbus_xcvr_chk #(
  parameter int W      = 8,
  parameter bit INVERT = 1'b0
) (
  input logic         clk_a2b,
  input logic         clk_b2a,
  input logic         rst,
  input logic         en_n,
  input logic         dir,
  input logic         sel_a2b,
  input logic         sel_b2a,
  input logic [W-1:0] a_in,
  input logic [W-1:0] b_in,
  input logic [W-1:0] a_out,
  input logic         a_oe,
  input logic [W-1:0] b_out,
  input logic         b_oe,
  input logic [W-1:0] a2b_q,
  input logic [W-1:0] b2a_q
);
  localparam logic [W-1:0] MASK = INVERT ? {W{1'b1}} : '0;

  p_cap_a_r1: assert property (@(posedge clk_a2b) disable iff (rst)
    !rst |=> (a2b_q == $past(a_in)));

  p_cap_b_r2: assert property (@(posedge clk_b2a) disable iff (rst)
    !rst |=> (b2a_q == $past(b_in)));

  always_comb begin
    if (en_n) p_iso_r4: assert (!a_oe && !b_oe);
    p_one_side_r5: assert (!(a_oe && b_oe));
    if (!en_n) p_dir_r5: assert (b_oe == dir);
    if (b_oe && !sel_a2b) p_live_b_r6: assert (b_out == (a_in ^ MASK));
    if (a_oe && !sel_b2a) p_live_a_r7: assert (a_out == (b_in ^ MASK));
    if (!a_oe) p_idle_a_r8: assert (a_out == '0);
    if (!b_oe) p_idle_b_r8: assert (b_out == '0);
    if (b_oe && sel_a2b) p_stored_b_r6: assert (b_out == (a2b_q ^ MASK));
    if (a_oe && sel_b2a) p_stored_a_r7: assert (a_out == (b2a_q ^ MASK));
  end
endmodule

bind regbus_xcvr regbus_xcvr_chk #(.W(W), .INVERT(INVERT)) u_chk (
  .clk_a2b(clk_a2b), .clk_b2a(clk_b2a), .rst(rst), .en_n(en_n), .dir(dir),
  .sel_a2b(sel_a2b), .sel_b2a(sel_b2a), .a_in(a_in), .b_in(b_in),
  .a_out(a_out), .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe),
  .a2b_q(a2b_q), .b2a_q(b2a_q)
);

// File: tb/regbus_xcvr_test.sv
`timescale 1ns/1ps
module regbus_xcvr_test;
  localparam int CLK_P = 10;
  localparam int W = 8;

  logic clk = 1'b0;
  logic clk_a2b = 1'b0, clk_b2a = 1'b0, rst = 1'b0;
  logic en_n = 1'b1, dir = 1'b0, sel_a2b = 1'b0, sel_b2a = 1'b0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic [W-1:0] a_out, b_out, ia_out, ib_out;
  logic a_oe, b_oe, ia_oe, ib_oe;

  logic [W-1:0] ra, rb;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  regbus_xcvr #(.W(W), .INVERT(1'b0)) uut (
    .clk_a2b(clk_a2b), .clk_b2a(clk_b2a), .rst(rst), .en_n(en_n), .dir(dir),
    .sel_a2b(sel_a2b), .sel_b2a(sel_b2a), .a_in(a_in), .b_in(b_in),
    .a_out(a_out), .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe));

  regbus_xcvr #(.W(W), .INVERT(1'b1)) uut_inv (
    .clk_a2b(clk_a2b), .clk_b2a(clk_b2a), .rst(rst), .en_n(en_n), .dir(dir),
    .sel_a2b(sel_a2b), .sel_b2a(sel_b2a), .a_in(a_in), .b_in(b_in),
    .a_out(ia_out), .a_oe(ia_oe), .b_out(ib_out), .b_oe(ib_oe));

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h (en_n=%b dir=%b sab=%b sba=%b)",
               req, act, exp, en_n, dir, sel_a2b, sel_b2a);
    end
  endtask

  task automatic pulse_a();
    @(negedge clk); clk_a2b = 1'b1;
    #(CLK_P/2) clk_a2b = 1'b0;
    if (rst) ra = '0; else ra = a_in;
  endtask

  task automatic pulse_b();
    @(negedge clk); clk_b2a = 1'b1;
    #(CLK_P/2) clk_b2a = 1'b0;
    if (rst) rb = '0; else rb = b_in;
  endtask

  task automatic check_all();
    logic eb, ea;
    logic [W-1:0] sb, sa;
    #1;
    eb = !en_n && dir;
    ea = !en_n && !dir;
    sb = sel_a2b ? ra : a_in;
    sa = sel_b2a ? rb : b_in;
    chk(en_n ? "R4 b_oe" : "R5 b_oe", {7'd0, b_oe}, {7'd0, eb});
    chk(en_n ? "R4 a_oe" : "R5 a_oe", {7'd0, a_oe}, {7'd0, ea});
    chk("R5 inv b_oe", {7'd0, ib_oe}, {7'd0, eb});
    chk("R5 inv a_oe", {7'd0, ia_oe}, {7'd0, ea});
    chk(eb ? "R6 b_out" : "R8 b_out", b_out, eb ? sb : '0);
    chk(ea ? "R7 a_out" : "R8 a_out", a_out, ea ? sa : '0);
    chk(eb ? "R9 inv b_out" : "R8 R9 inv b_out", ib_out, eb ? ~sb : '0);
    chk(ea ? "R9 inv a_out" : "R8 R9 inv a_out", ia_out, ea ? ~sa : '0);
  endtask

  task automatic show_stored(input string req);
    en_n = 1'b0; sel_a2b = 1'b1; sel_b2a = 1'b1;
    dir = 1'b1; #1; chk(req, b_out, ra); chk(req, ib_out, ~ra);
    dir = 1'b0; #1; chk(req, a_out, rb); chk(req, ia_out, ~rb);
  endtask

  initial begin
    // R3: clear both registers at start
    rst = 1'b1; pulse_a(); pulse_b(); rst = 1'b0;
    show_stored("R3 reset");

    // R1/R2: captures under every control setting, read back stored path
    for (int c = 0; c < 16; c++) begin
      {en_n, dir, sel_a2b, sel_b2a} = c[3:0];
      a_in = 8'h11 * c[3:0] ^ 8'h5A;
      b_in = ~(8'h0F + 8'd13 * c[7:0]);
      pulse_a();
      {en_n, dir, sel_a2b, sel_b2a} = ~c[3:0];
      pulse_b();
      a_in = 8'h00; b_in = 8'hFF;
      show_stored("R1 R2 capture");
    end

    // R3: reset on one clock leaves the other register
    a_in = 8'hC3; b_in = 8'h96; pulse_a(); pulse_b();
    rst = 1'b1; pulse_a(); rst = 1'b0;
    show_stored("R3 clear a only");
    a_in = 8'h7E; pulse_a();
    rst = 1'b1; pulse_b(); rst = 1'b0;
    show_stored("R3 clear b only");

    // R4-R9: sweep controls across data patterns
    for (int p = 0; p < 6; p++) begin
      a_in = 8'hA5 ^ (8'h1 << p); b_in = 8'h3C + 8'd29 * p[7:0];
      pulse_a();
      b_in = ~b_in; pulse_b();
      a_in = {a_in[0], a_in[7:1]}; b_in = b_in ^ 8'hF0;
      for (int c = 0; c < 16; c++) begin
        {en_n, dir, sel_a2b, sel_b2a} = c[3:0];
        check_all();
        a_in = a_in + 8'd37; b_in = b_in - 8'd53;
        check_all();
      end
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 20000; i++) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog act=running exp=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule